// File: doc/BRIEF.md
# Write-Gated Serial Peripheral Slave

This block is the serial front end of a small byte-addressed storage device. It runs on a fast system clock and oversamples the serial clock, chip select, data input and write-protect pins. It recovers SPI mode-0 frames from them: a command byte, then an address byte, then a data byte, with the most significant bit first. Read commands return the addressed byte on the serial output. Write commands become a one-clock write request, and a write-busy window follows it. A small internal byte array and a cycle counter stand in for the real storage and its programming time.

Two rules govern which frames take effect. After the power-up reset the block does nothing until it has seen chip select go from high to low, so a frame that was already in progress at power-up is lost. The write-protect pin is checked for the whole of a write frame. If it is low at any sampled point before the closing chip-select edge, the write is dropped. Once a write cycle is running, write-protect no longer has any effect on it.

Top module: `spi_wp_slave`

## Requirements
- R1: si is taken on each rising sck edge. A frame is an 8-bit command, then an 8-bit address, then 8 data bits, each sent MSB first.
- R2: so changes only in the clock cycle after a detected falling sck edge. Command 0x03 (read) returns the stored byte at the address, MSB first. The first bit appears after the falling edge that follows the 16th rising edge.
- R3: so_oe is low after reset. It goes low within two clocks of cs_n going high. It is high only during the data phase of a read frame.
- R4: After reset, no frame is accepted until cs_n has gone from high to low. A frame that begins with cs_n already low produces no write and no output enable.
- R5: A frame with command 0x02 (write) and exactly 24 rising sck edges is committed on the rising edge of cs_n. Commit gives a one-clock wr_req that carries the captured address and data, and the stored byte at that address is updated.
- R6: A write frame that ends after fewer or more than 24 rising sck edges gives no write.
- R7: If wp_n is low at any sampled point from the start of a frame through the closing cs_n rise, the write is dropped. Reads work normally while wp_n is low.
- R8: Driving wp_n low while a write cycle is running does not shorten wr_busy or cancel that write.
- R9: wr_busy is high for exactly WRITE_CYCLES clocks, starting in the cycle of wr_req. A write frame that completes while wr_busy is high is dropped.
- R10: Any command other than 0x02 and 0x03 leaves so_oe low and gives no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than sck |
| rst_n | input | 1 | Active-low power-up reset |
| sck | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data input |
| wp_n | input | 1 | Active-low write protect |
| so | output | 1 | Serial data output value |
| so_oe | output | 1 | Output enable for so; low means high impedance |
| wr_req | output | 1 | One-clock pulse for a committed write |
| wr_addr | output | ADDR_W | Address of the committed write |
| wr_data | output | DATA_W | Data of the committed write |
| wr_busy | output | 1 | Internal write cycle in progress |

## Verification
The assertions assume that sck, cs_n, si and wp_n are slow next to clk. Each level is taken to hold for several clocks, so that every pin edge is seen as exactly one sampled edge. They also assume that sck is low whenever cs_n changes. The stimulus keeps to this rule. It changes pins only on the falling clock edge and holds each sck level for four clocks. It moves chip select only while sck is low, and it changes write-protect only between sck edges or while chip select is high.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;
  localparam int OP_W = 8;

  typedef logic [OP_W-1:0] opcode_t;

  localparam opcode_t OPC_WRITE = 8'h02;
  localparam opcode_t OPC_READ  = 8'h03;
  localparam opcode_t OPC_NONE  = 8'hFF;

  // a write frame commits only when every gate is open
  function automatic logic write_allowed(input opcode_t op, input logic full,
                                         input logic cut, input logic wp_ok,
                                         input logic busy);
    return (op == OPC_WRITE) && full && !cut && wp_ok && !busy;
  endfunction

  // a read starts driving at the boundary between address and data
  function automatic logic read_begins(input opcode_t op, input logic at_boundary);
    return (op == OPC_READ) && at_boundary;
  endfunction
endpackage

// File: rtl/spi_pin_sampler.sv
module spi_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic wp_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic cs_low,
  output logic si_s,
  output logic wp_s,
  output logic armed
);
  logic sck_q, sck_p, cs_q, cs_p, si_q, wp_q, armed_q;

  // chip select history starts as "selected" so that a frame already
  // running at power-up never looks like a fresh falling edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      sck_p   <= 1'b0;
      cs_q    <= 1'b0;
      cs_p    <= 1'b0;
      si_q    <= 1'b0;
      wp_q    <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      sck_q <= sck;
      sck_p <= sck_q;
      cs_q  <= cs_n;
      cs_p  <= cs_q;
      si_q  <= si;
      wp_q  <= wp_n;
      if (cs_p && !cs_q) armed_q <= 1'b1;
    end
  end

  assign sck_rise = sck_q && !sck_p;
  assign sck_fall = !sck_q && sck_p;
  assign cs_fall  = !cs_q && cs_p;
  assign cs_rise  = cs_q && !cs_p;
  assign cs_low   = !cs_q;
  assign si_s     = si_q;
  assign wp_s     = wp_q;
  assign armed    = armed_q;
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_wp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int FRAME_BITS = OP_W + ADDR_W + DATA_W,
  localparam int CNT_W = $clog2(FRAME_BITS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_active,
  input  logic              cs_fall,
  input  logic              sck_rise,
  input  logic              si_s,
  output opcode_t           op,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              count_full,
  output logic              at_data_start
);
  localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_OP    = CNT_W'(OP_W - 1);
  localparam logic [CNT_W-1:0] CNT_ADDR  = CNT_W'(OP_W + ADDR_W - 1);
  localparam logic [CNT_W-1:0] CNT_DATA  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_BOUND = CNT_W'(OP_W + ADDR_W);

  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] sh, sh_next;

  function automatic logic [FRAME_BITS-1:0] shift_in(input logic [FRAME_BITS-1:0] v,
                                                     input logic b);
    return {v[FRAME_BITS-2:0], b};
  endfunction

  assign sh_next = shift_in(sh, si_s);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      sh      <= '0;
      op      <= OPC_NONE;
      addr    <= '0;
      data    <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
    end else if (sck_rise && frame_active) begin
      sh <= sh_next;
      if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == CNT_OP)   op   <= sh_next[OP_W-1:0];
      if (bit_cnt == CNT_ADDR) addr <= sh_next[ADDR_W-1:0];
      if (bit_cnt == CNT_DATA) data <= sh_next[DATA_W-1:0];
    end
  end

  assign count_full    = (bit_cnt == CNT_FULL);
  assign at_data_start = (bit_cnt == CNT_BOUND);
endmodule

// File: rtl/spi_tx.sv
module spi_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_active,
  input  logic              sck_fall,
  input  logic              rd_start,
  input  logic [DATA_W-1:0] rd_byte,
  output logic              so,
  output logic              so_oe
);
  logic [DATA_W-1:0] out_sh;

  // output moves only on the sampled falling edge of sck
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      so     <= 1'b0;
      so_oe  <= 1'b0;
      out_sh <= '0;
    end else if (!frame_active) begin
      so     <= 1'b0;
      so_oe  <= 1'b0;
      out_sh <= '0;
    end else if (sck_fall) begin
      if (rd_start) begin
        so     <= rd_byte[DATA_W-1];
        out_sh <= {rd_byte[DATA_W-2:0], 1'b0};
        so_oe  <= 1'b1;
      end else if (so_oe) begin
        so     <= out_sh[DATA_W-1];
        out_sh <= {out_sh[DATA_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_wr_gate.sv
module spi_wr_gate
  import spi_wp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int WRITE_CYCLES = 256,
  localparam int BUSY_W = $clog2(WRITE_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_active,
  input  logic              cs_rise,
  input  logic              wp_s,
  input  logic              count_full,
  input  opcode_t           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_busy,
  output logic [BUSY_W-1:0] busy_left
);
  localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(WRITE_CYCLES - 1);

  logic wp_cut;
  logic commit;

  assign commit = cs_rise && write_allowed(op, count_full, wp_cut, wp_s, wr_busy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_cut    <= 1'b0;
      wr_req    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_busy   <= 1'b0;
      busy_left <= '0;
    end else begin
      if (cs_rise)                    wp_cut <= 1'b0;
      else if (frame_active && !wp_s) wp_cut <= 1'b1;

      wr_req <= commit;
      if (commit) begin
        wr_addr <= addr;
        wr_data <= data;
      end

      // the running cycle ignores write protect entirely
      if (commit) begin
        wr_busy   <= 1'b1;
        busy_left <= BUSY_LOAD;
      end else if (wr_busy) begin
        if (busy_left == '0) wr_busy <= 1'b0;
        else                 busy_left <= busy_left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_wp_slave.sv
module spi_wp_slave
  import spi_wp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int WRITE_CYCLES = 256,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int BUSY_W = $clog2(WRITE_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              wp_n,
  output logic              so,
  output logic              so_oe,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_busy
);
  logic sck_rise, sck_fall, cs_fall, cs_rise, cs_low, si_s, wp_s, armed;
  logic frame_active;
  opcode_t op;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic count_full, at_data_start, rd_start;
  logic [DATA_W-1:0] rd_byte;
  logic [BUSY_W-1:0] busy_left;
  logic [DATA_W-1:0] store [DEPTH];

  spi_pin_sampler u_pins (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .cs_low(cs_low), .si_s(si_s), .wp_s(wp_s), .armed(armed)
  );

  assign frame_active = armed && cs_low;

  spi_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .frame_active(frame_active), .cs_fall(cs_fall),
    .sck_rise(sck_rise), .si_s(si_s), .op(op), .addr(addr), .data(data),
    .count_full(count_full), .at_data_start(at_data_start)
  );

  assign rd_start = read_begins(op, at_data_start);
  assign rd_byte  = store[addr];

  spi_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame_active(frame_active), .sck_fall(sck_fall),
    .rd_start(rd_start), .rd_byte(rd_byte), .so(so), .so_oe(so_oe)
  );

  spi_wr_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_CYCLES(WRITE_CYCLES)) u_wr (
    .clk(clk), .rst_n(rst_n), .frame_active(frame_active), .cs_rise(cs_rise),
    .wp_s(wp_s), .count_full(count_full), .op(op), .addr(addr), .data(data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_busy(wr_busy),
    .busy_left(busy_left)
  );

  // stand-in storage, updated by each committed write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else if (wr_req) begin
      store[wr_addr] <= wr_data;
    end
  end
endmodule

// File: rtl/spi_wp_slave_chk.sv
module spi_wp_slave_chk #(
  parameter int BUSY_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              so,
  input logic              so_oe,
  input logic              wr_req,
  input logic              wr_busy,
  input logic              armed,
  input logic              frame_active,
  input logic              wp_s,
  input logic              sck_fall,
  input logic [BUSY_W-1:0] busy_left
);
  // R2
  so_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && $past(so_oe) && !$past(sck_fall)) |-> $stable(so));

  // R3
  so_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |=> !so_oe);

  // R4
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!wr_req && !so_oe));

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);

  // R5
  wr_busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wr_busy);

  // R7
  wp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> $past(wp_s));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_busy && busy_left != '0) |=> wr_busy);

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !$past(wr_busy));
endmodule

bind spi_wp_slave spi_wp_slave_chk #(.BUSY_W(BUSY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .so(so), .so_oe(so_oe), .wr_req(wr_req),
  .wr_busy(wr_busy), .armed(armed), .frame_active(frame_active), .wp_s(wp_s),
  .sck_fall(sck_fall), .busy_left(busy_left)
);

// File: tb/spi_wp_slave_test.sv
module spi_wp_slave_test;
  localparam int WC = 300;
  localparam int H  = 4;

  logic clk = 1'b0;
  logic rst_n, sck, cs_n, si, wp_n;
  logic so, so_oe, wr_req, wr_busy;
  logic [7:0] wr_addr, wr_data;

  int checks = 0, errors = 0;
  int wr_seen = 0;
  logic [7:0] last_addr, last_data;
  int busy_run = 0, last_busy_len = 0;
  bit so_oe_seen = 0;
  int hi_streak = 0, sck_age = 0;
  logic so_prev = 0, oe_prev = 0, sck_prev = 0;
  logic [7:0] model_mem [256];
  bit done = 0;

  always #5 clk = ~clk;

  spi_wp_slave #(.WRITE_CYCLES(WC)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n),
    .so(so), .so_oe(so_oe), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_busy(wr_busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock observation, sampled two time units after the rising edge
  always begin
    @(posedge clk);
    #2;
    if (rst_n) begin
      if (so_oe) so_oe_seen = 1;
      // R3: two samples of deselect mean the output must be released
      hi_streak = cs_n ? hi_streak + 1 : 0;
      if (hi_streak >= 2) check(!so_oe, "R3", so_oe, 0);
      // R2: so may move only shortly after a falling sck
      if (sck_prev && !sck) sck_age = 0; else sck_age++;
      if (so_oe && oe_prev && so != so_prev) check(sck_age <= 2, "R2", sck_age, 2);
      if (wr_req) begin
        wr_seen++;
        last_addr = wr_addr;
        last_data = wr_data;
      end
      if (wr_busy) busy_run++;
      else if (busy_run > 0) begin
        last_busy_len = busy_run;
        check(busy_run == WC, "R9", busy_run, WC);
        busy_run = 0;
      end
      so_prev = so; oe_prev = so_oe; sck_prev = sck;
    end
  end

  task automatic send_frame(input logic [7:0] op, input logic [7:0] ad,
                            input logic [7:0] dt, input int nbits, input bit no_fall,
                            input int wp_lo, input int wp_hi, output logic [7:0] rx);
    logic [23:0] word;
    word = {op, ad, dt};
    rx = '0;
    so_oe_seen = 0;
    sck = 0;
    if (!no_fall) cs_n = 0;
    wait_clk(H);
    for (int i = 0; i < nbits; i++) begin
      sck = 0;
      si = (i < 24) ? word[23-i] : 1'b0;
      if (i == wp_lo) wp_n = 0;
      if (i == wp_hi) wp_n = 1;
      wait_clk(H);
      if (i >= 16 && i < 24) rx = {rx[6:0], so};
      sck = 1;
      wait_clk(H);
    end
    sck = 0;
    wait_clk(H);
    cs_n = 1;
    wait_clk(4);
  endtask

  task automatic do_write(input logic [7:0] ad, input logic [7:0] dt);
    logic [7:0] rx;
    send_frame(8'h02, ad, dt, 24, 0, -1, -1, rx);
  endtask

  task automatic do_read(input logic [7:0] ad, output logic [7:0] rx);
    send_frame(8'h03, ad, 8'h00, 24, 0, -1, -1, rx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [7:0] rx;
    int w0;
    for (int i = 0; i < 256; i++) model_mem[i] = 8'h00;
    rst_n = 0; sck = 0; si = 0; wp_n = 1;
    cs_n = 0;                       // powered up already selected
    wait_clk(5);
    rst_n = 1;
    wait_clk(3);

    // R3: reset state
    check(!so_oe, "R3 reset so_oe", so_oe, 0);
    check(!wr_busy, "R3 reset wr_busy", wr_busy, 0);
    check(!wr_req, "R3 reset wr_req", wr_req, 0);

    // R4: a frame that began before any falling chip select is ignored
    w0 = wr_seen;
    send_frame(8'h02, 8'h20, 8'h3C, 24, 1, -1, -1, rx);
    check(wr_seen == w0, "R4 no write", wr_seen - w0, 0);
    check(!so_oe_seen, "R4 no output", so_oe_seen, 0);

    // R5, R1: full write frame
    w0 = wr_seen;
    do_write(8'h10, 8'hA5);
    model_mem[8'h10] = 8'hA5;
    check(wr_seen == w0 + 1, "R5 write count", wr_seen - w0, 1);
    check(last_addr == 8'h10, "R1 addr", last_addr, 8'h10);
    check(last_data == 8'hA5, "R1 data", last_data, 8'hA5);
    wait_clk(WC + 10);

    // R2, R3: read back drives so during the data phase
    do_read(8'h10, rx);
    check(rx == model_mem[8'h10], "R2 read data", rx, model_mem[8'h10]);
    check(so_oe_seen, "R3 oe in read", so_oe_seen, 1);

    // R6: short and long write frames
    w0 = wr_seen;
    send_frame(8'h02, 8'h11, 8'h77, 20, 0, -1, -1, rx);
    check(wr_seen == w0, "R6 short frame", wr_seen - w0, 0);
    send_frame(8'h02, 8'h11, 8'h77, 25, 0, -1, -1, rx);
    check(wr_seen == w0, "R6 long frame", wr_seen - w0, 0);
    do_read(8'h11, rx);
    check(rx == model_mem[8'h11], "R6 location unchanged", rx, model_mem[8'h11]);

    // R7: protected for the whole frame, reads still work
    w0 = wr_seen;
    send_frame(8'h02, 8'h12, 8'h99, 24, 0, 0, -1, rx);
    check(wr_seen == w0, "R7 wp whole frame", wr_seen - w0, 0);
    do_read(8'h10, rx);
    check(rx == model_mem[8'h10], "R7 read under wp", rx, model_mem[8'h10]);
    do_read(8'h12, rx);
    check(rx == model_mem[8'h12], "R7 no store", rx, model_mem[8'h12]);
    wp_n = 1;
    wait_clk(4);

    // R7: brief protect pulse inside the frame still cancels
    send_frame(8'h02, 8'h12, 8'h66, 24, 0, 5, 12, rx);
    check(wr_seen == w0, "R7 wp mid frame", wr_seen - w0, 0);

    // R8: protect during a running cycle has no effect
    w0 = wr_seen;
    do_write(8'h13, 8'h5A);
    model_mem[8'h13] = 8'h5A;
    wp_n = 0;
    wait_clk(WC + 10);
    wp_n = 1;
    check(wr_seen == w0 + 1, "R8 write kept", wr_seen - w0, 1);
    check(last_busy_len == WC, "R8 busy length", last_busy_len, WC);
    do_read(8'h13, rx);
    check(rx == model_mem[8'h13], "R8 data stored", rx, model_mem[8'h13]);

    // R9: a write finishing during busy is dropped
    w0 = wr_seen;
    do_write(8'h14, 8'h11);
    model_mem[8'h14] = 8'h11;
    check(wr_busy, "R9 busy after write", wr_busy, 1);
    do_write(8'h15, 8'h22);
    check(wr_seen == w0 + 1, "R9 second dropped", wr_seen - w0, 1);
    wait_clk(WC + 10);
    do_read(8'h15, rx);
    check(rx == model_mem[8'h15], "R9 location untouched", rx, model_mem[8'h15]);
    do_read(8'h14, rx);
    check(rx == model_mem[8'h14], "R9 first stored", rx, model_mem[8'h14]);

    // R10: unknown command
    w0 = wr_seen;
    send_frame(8'h55, 8'h10, 8'hFF, 24, 0, -1, -1, rx);
    check(wr_seen == w0, "R10 no write", wr_seen - w0, 0);
    check(!so_oe_seen, "R10 no output", so_oe_seen, 0);

    // R1: bit order with asymmetric patterns
    do_write(8'h81, 8'hC3);
    model_mem[8'h81] = 8'hC3;
    check(last_addr == 8'h81, "R1 msb-first addr", last_addr, 8'h81);
    wait_clk(WC + 10);
    do_read(8'h81, rx);
    check(rx == model_mem[8'h81], "R1 R2 msb-first read", rx, model_mem[8'h81]);

    done = 1;
    report();
  end
endmodule